// File: doc/BRIEF.md
# SPI Memory Command Sequencer

This block is a single-lane SPI host that carries out one complete serial-flash command per trigger. Software fills a 128-byte shared buffer through a 32-bit register port. The buffer holds the opcode, the address bytes, any dummy bytes and any write payload. Software then programs how many bytes go out and how many come back, and fires the engine. The engine drives chip select low and clocks the outgoing bytes from buffer index 0 upward. It then clocks in the requested number of bytes and stores them in the same buffer, starting at the index just past the last outgoing byte.

Software follows the engine through two flags in the control word. The in-progress flag rises when the trigger is accepted and falls once chip select has been held high for the programmed gap. The ready flag rises when chip select first goes low. Writing the control word with the enable bit clear ends the command and clears both flags. A software-reset bit in the miscellaneous word returns the engine to idle at once.

Top module: `spi_cmd_seq`

## Requirements
- R1: After reset, chip select is high, SCLK and MOSI are low, and the control word (0x500) and the state word (0x550) both read 0.
- R2: Several fields read back as written. In the control word these are the extended-I/O bit 4 and the enable bit 3. The output count (0x504) and input count (0x508) hold 8 bits. The miscellaneous word (0x538) holds read latency at bits 26:25, latch latency at bits 9:8 and the deselect count at bits 4:0. The trigger (control bit 2) and the software reset (miscellaneous bit 28) always read 0.
- R3: The buffer is 32 words mapped at 0x800–0x87F. Each word reads back as written. Byte k of the buffer is bits 8*(k%4)+7 : 8*(k%4) of word k/4.
- R4: A control write with bit 3 and bit 2 both set, made while the engine is idle, sets the busy flag (bit 0) on that clock edge. Chip select goes low and the ready flag (bit 1) sets on the next edge.
- R5: Transfers use SPI mode 0 with MSB first. SCLK idles low and runs at half the core clock. MOSI never changes in the same cycle that SCLK rises. Each transaction produces exactly 8 × (output count + input count) SCLK rising edges.
- R6: The output bytes go out on MOSI in buffer order from index 0. MOSI stays low while the input bytes are clocked.
- R7: Input byte j is written to buffer index (output count + j).
- R8: Chip select stays low from the first bit to the last. After the last byte it is high for exactly (deselect count + 1) cycles before the busy flag clears.
- R9: Writing the control word with bit 3 clear clears busy and ready, drives chip select high and stops the transfer. The ready flag stays set after a normal finish until then.
- R10: While busy is set, writes to the buffer, to either count, and further trigger writes have no effect.
- R11: Writing miscellaneous bit 28 as 1 returns the engine to idle at the next edge. After that the state word reads 0, chip select is high and busy is clear, and the other miscellaneous fields take the written values.
- R12: The state word (0x550, bits 3:0) is nonzero while a transaction is running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Byte address of the register or buffer word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |

## Verification
The delicate overlap is a new trigger write that lands while the engine is still timing the chip-select gap after the last byte. In that cycle the command decoder and the gap counter both act on the same state. The bench waits for chip select to rise and then writes enable with trigger in that window. It judges the result in three ways: chip select must stay high, no extra SCLK edges may appear, and busy must still clear exactly deselect+1 cycles after the rise.

// File: rtl/spi_seq_pkg.sv
// Package: register offsets and engine state encoding shared by the sequencer.
// Assumes a 12-bit byte address space on the register port.
package spi_seq_pkg;
    localparam logic [11:0] OFS_CTRL  = 12'h500;
    localparam logic [11:0] OFS_OUTC  = 12'h504;
    localparam logic [11:0] OFS_INC   = 12'h508;
    localparam logic [11:0] OFS_MISC  = 12'h538;
    localparam logic [11:0] OFS_STATE = 12'h550;
    localparam logic [11:0] OFS_BUF   = 12'h800;

    // Engine state; value 0 must mean idle (read by software).
    typedef enum logic [3:0] {
        ST_IDLE  = 4'd0,
        ST_START = 4'd1,
        ST_ISSUE = 4'd2,
        ST_WAIT  = 4'd3,
        ST_GAP   = 4'd4
    } seq_state_t;
endpackage

// File: rtl/spi_seq_buf.sv
// Shared byte buffer, organised as four byte lanes of WORDS entries.
// Port A: whole-word bus write/read. Port B: single-byte engine write/read.
// Assumes the owner never enables both writes to the same word in one cycle;
// bus write has priority if it does.
module spi_seq_buf #(
    parameter int BYTES = 128
) (
    input  logic                          clk,
    input  logic                          bus_we,
    input  logic [$clog2(BYTES/4)-1:0]    bus_idx,
    input  logic [31:0]                   bus_wdata,
    output logic [31:0]                   bus_rdata,
    input  logic                          eng_we,
    input  logic [$clog2(BYTES)-1:0]      eng_idx,
    input  logic [7:0]                    eng_wbyte,
    output logic [7:0]                    eng_rbyte
);
    localparam int WORDS = BYTES / 4;
    localparam int BW    = $clog2(BYTES);

    logic [7:0] lane_rd [4];

    for (genvar g = 0; g < 4; g++) begin : g_lane
        logic [7:0] mem [WORDS];

        // Lane storage: bus word write or engine byte write into this lane.
        always_ff @(posedge clk) begin
            if (bus_we)
                mem[bus_idx] <= bus_wdata[8*g +: 8];
            else if (eng_we && eng_idx[1:0] == 2'(g))
                mem[eng_idx[BW-1:2]] <= eng_wbyte;
        end

        assign bus_rdata[8*g +: 8] = mem[bus_idx];
        assign lane_rd[g]          = mem[eng_idx[BW-1:2]];
    end

    assign eng_rbyte = lane_rd[eng_idx[1:0]];
endmodule

// File: rtl/spi_seq_shift.sv
// Mode-0 byte shifter: MSB first, SCLK = clk/2, idles low.
// MOSI updates with the falling SCLK, MISO is taken in the high half.
// 'go' loads a byte; 'done' pulses one cycle when the byte is complete.
module spi_seq_shift #(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            abort,
    input  logic            go,
    input  logic [BITS-1:0] tx_byte,
    input  logic            miso,
    output logic            sclk,
    output logic            mosi,
    output logic            done,
    output logic [BITS-1:0] rx_byte
);
    localparam int CW = $clog2(BITS);

    logic            active;
    logic [BITS-1:0] sh;
    logic [CW-1:0]   bit_n;

    // Bit engine: alternate SCLK halves, shift out on fall, capture on high.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            active  <= 1'b0;
            sclk    <= 1'b0;
            mosi    <= 1'b0;
            done    <= 1'b0;
            sh      <= '0;
            bit_n   <= '0;
            rx_byte <= '0;
        end else begin
            done <= 1'b0;
            if (go) begin
                active <= 1'b1;
                sclk   <= 1'b0;
                sh     <= tx_byte;
                mosi   <= tx_byte[BITS-1];
                bit_n  <= '0;
            end else if (active) begin
                if (!sclk) begin
                    sclk <= 1'b1;
                end else begin
                    sclk    <= 1'b0;
                    rx_byte <= {rx_byte[BITS-2:0], miso};
                    if (bit_n == CW'(BITS-1)) begin
                        active <= 1'b0;
                        done   <= 1'b1;
                        mosi   <= 1'b0;
                    end else begin
                        bit_n <= bit_n + 1'b1;
                        sh    <= {sh[BITS-2:0], 1'b0};
                        mosi  <= sh[BITS-2];
                    end
                end
            end
        end
    end

    // R5: data line is steady whenever the clock rises.
    p_mosi_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> $stable(mosi));
    // R5: clock stays low whenever no byte is in flight.
    p_sclk_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !go) |=> !sclk);
endmodule

// File: rtl/spi_cmd_seq.sv
// SPI memory command sequencer top: register decode, buffer, sequencing FSM
// and deselect timer around a mode-0 shifter.
// Assumes software keeps output count + input count <= BUF_BYTES; input bytes
// past the buffer end are clocked but not stored.
module spi_cmd_seq
    import spi_seq_pkg::*;
#(
    parameter int BUF_BYTES = 128,
    parameter int CNT_W     = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [11:0] reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        spi_sclk,
    output logic        spi_cs_n,
    output logic        spi_mosi,
    input  logic        spi_miso
);
    localparam int BW    = $clog2(BUF_BYTES);
    localparam int AW    = BW - 2;
    localparam int IDX_W = CNT_W + 1;
    localparam int GAP_W = 5;

    seq_state_t       state;
    logic             en_q, xio_q, busy_q, ready_q;
    logic [CNT_W-1:0] out_cnt, in_cnt;
    logic [1:0]       rd_lat, latch_lat;
    logic [GAP_W-1:0] gap_len, gap_cnt;
    logic [IDX_W-1:0] idx, total;

    logic wr_ctrl, wr_outc, wr_inc, wr_misc, wr_buf, in_buf, srst, stop, trig;
    logic [31:0] buf_rdata;
    logic [7:0]  eng_rbyte, tx_byte, rx_byte;
    logic        eng_we, sh_go, sh_done;
    logic        unused_bits;

    assign in_buf  = (reg_addr >= OFS_BUF) && (reg_addr < OFS_BUF + 12'(BUF_BYTES));
    assign wr_ctrl = reg_wr && reg_addr == OFS_CTRL;
    assign wr_outc = reg_wr && reg_addr == OFS_OUTC;
    assign wr_inc  = reg_wr && reg_addr == OFS_INC;
    assign wr_misc = reg_wr && reg_addr == OFS_MISC;
    assign wr_buf  = reg_wr && in_buf;
    assign srst    = wr_misc && reg_wdata[28];
    assign stop    = wr_ctrl && !reg_wdata[3];
    assign trig    = wr_ctrl && reg_wdata[3] && reg_wdata[2];
    assign total   = {1'b0, out_cnt} + {1'b0, in_cnt};
    assign unused_bits = ^{reg_wdata[31:29], reg_wdata[27], reg_wdata[24:10]};

    // Setup registers: counts frozen while busy, misc always writable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_cnt   <= '0;
            in_cnt    <= '0;
            rd_lat    <= '0;
            latch_lat <= '0;
            gap_len   <= '0;
        end else begin
            if (wr_outc && !busy_q) out_cnt <= reg_wdata[CNT_W-1:0];
            if (wr_inc && !busy_q)  in_cnt  <= reg_wdata[CNT_W-1:0];
            if (wr_misc) begin
                rd_lat    <= reg_wdata[26:25];
                latch_lat <= reg_wdata[9:8];
                gap_len   <= reg_wdata[GAP_W-1:0];
            end
        end
    end

    // Sequencer: trigger, chip select, byte stepping, deselect gap, abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            en_q     <= 1'b0;
            xio_q    <= 1'b0;
            busy_q   <= 1'b0;
            ready_q  <= 1'b0;
            spi_cs_n <= 1'b1;
            idx      <= '0;
            gap_cnt  <= '0;
        end else begin
            if (wr_ctrl) begin
                en_q  <= reg_wdata[3];
                xio_q <= reg_wdata[4];
            end
            if (srst || stop) begin
                state    <= ST_IDLE;
                busy_q   <= 1'b0;
                ready_q  <= 1'b0;
                spi_cs_n <= 1'b1;
            end else begin
                unique case (state)
                    ST_IDLE: if (trig) begin
                        busy_q <= 1'b1;
                        idx    <= '0;
                        state  <= ST_START;
                    end
                    ST_START: begin
                        spi_cs_n <= 1'b0;
                        ready_q  <= 1'b1;
                        gap_cnt  <= '0;
                        state    <= (total == '0) ? ST_GAP : ST_ISSUE;
                    end
                    ST_ISSUE: state <= ST_WAIT;
                    ST_WAIT: if (sh_done) begin
                        idx <= idx + 1'b1;
                        if (idx + 1'b1 == total) begin
                            spi_cs_n <= 1'b1;
                            gap_cnt  <= '0;
                            state    <= ST_GAP;
                        end else begin
                            state <= ST_ISSUE;
                        end
                    end
                    ST_GAP: begin
                        spi_cs_n <= 1'b1;
                        if (gap_cnt == gap_len) begin
                            busy_q <= 1'b0;
                            state  <= ST_IDLE;
                        end else begin
                            gap_cnt <= gap_cnt + 1'b1;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    assign sh_go   = (state == ST_ISSUE);
    assign tx_byte = (idx < {1'b0, out_cnt}) ? eng_rbyte : 8'h00;
    assign eng_we  = (state == ST_WAIT) && sh_done && (idx >= {1'b0, out_cnt})
                     && (idx < IDX_W'(BUF_BYTES));

    spi_seq_buf #(.BYTES(BUF_BYTES)) u_buf (
        .clk       (clk),
        .bus_we    (wr_buf && !busy_q),
        .bus_idx   (reg_addr[BW-1:2]),
        .bus_wdata (reg_wdata),
        .bus_rdata (buf_rdata),
        .eng_we    (eng_we),
        .eng_idx   (idx[BW-1:0]),
        .eng_wbyte (rx_byte),
        .eng_rbyte (eng_rbyte)
    );

    spi_seq_shift #(.BITS(8)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .abort   (srst || stop),
        .go      (sh_go),
        .tx_byte (tx_byte),
        .miso    (spi_miso),
        .sclk    (spi_sclk),
        .mosi    (spi_mosi),
        .done    (sh_done),
        .rx_byte (rx_byte)
    );

    // Read mux: control flags, counts, misc fields, engine state, buffer words.
    always_comb begin
        reg_rdata = '0;
        if (in_buf)
            reg_rdata = buf_rdata;
        else if (reg_addr == OFS_CTRL)
            reg_rdata = {27'b0, xio_q, en_q, 1'b0, ready_q, busy_q};
        else if (reg_addr == OFS_OUTC)
            reg_rdata = 32'(out_cnt);
        else if (reg_addr == OFS_INC)
            reg_rdata = 32'(in_cnt);
        else if (reg_addr == OFS_MISC) begin
            reg_rdata[26:25]       = rd_lat;
            reg_rdata[9:8]         = latch_lat;
            reg_rdata[GAP_W-1:0]   = gap_len;
        end else if (reg_addr == OFS_STATE)
            reg_rdata = {28'b0, state};
    end

    // R8: chip select is only ever low inside a busy transaction.
    p_cs_in_txn_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_cs_n |-> busy_q);
    // R9: ready can only be set with the enable bit held.
    p_ready_needs_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ready_q |-> en_q);
    // R10: count writes while busy leave the count unchanged.
    p_count_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_outc && busy_q) |=> $stable(out_cnt));
    // R11: software reset lands the engine in idle with chip select high.
    p_srst_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (state == ST_IDLE && spi_cs_n && !busy_q));
    // R4: an accepted trigger raises busy on the next cycle.
    p_trig_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && trig) |=> busy_q);
endmodule

// File: tb/tb_spi_cmd_seq.sv
`timescale 1ns/1ps
module tb_spi_cmd_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        spi_sclk, spi_cs_n, spi_mosi, spi_miso;

    int n_chk = 0;
    int n_fail = 0;
    bit done_flag = 0;

    always #2 clk = ~clk;

    spi_cmd_seq dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sclk(spi_sclk),
        .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    // Device model: shifts out on falling SCLK, captures MOSI on rising SCLK.
    logic [7:0] s_tx [16];
    logic [7:0] s_rx [16];
    int sbit = 0;
    int rises = 0;
    always @(negedge spi_cs_n) sbit = 0;
    always @(negedge spi_sclk) sbit = sbit + 1;
    always @(posedge spi_sclk) begin
        if (sbit < 128) s_rx[sbit/8][7-(sbit%8)] = spi_mosi;
        rises = rises + 1;
    end
    assign spi_miso = (sbit < 128) ? s_tx[sbit/8][7-(sbit%8)] : 1'b0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic start_txn(input int outn, input int inn);
        wr(12'h500, 32'h8);
        wr(12'h504, 32'(outn));
        wr(12'h508, 32'(inn));
        wr(12'h500, 32'hC);
    endtask

    task automatic wait_idle();
        reg_addr = 12'h500;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            #1 if (!reg_rdata[0]) break;
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk(spi_cs_n && !spi_sclk && !spi_mosi, "R1 pins", {29'b0, spi_cs_n, spi_sclk, spi_mosi}, 32'h4);
        rd(12'h500, v); chk(v == 0, "R1 ctrl", v, 0);
        rd(12'h550, v); chk(v == 0, "R1 state", v, 0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        wr(12'h538, (32'd2 << 25) | (32'd1 << 8) | 32'd10);
        rd(12'h538, v); chk(v == 32'h0400010A, "R2 misc", v, 32'h0400010A);
        wr(12'h504, 32'h1A5); rd(12'h504, v); chk(v == 32'hA5, "R2 outc", v, 32'hA5);
        wr(12'h508, 32'h03C); rd(12'h508, v); chk(v == 32'h3C, "R2 inc", v, 32'h3C);
        wr(12'h500, 32'h18); rd(12'h500, v); chk(v == 32'h18, "R2 ctrl", v, 32'h18);
        wr(12'h500, 32'h0);
    endtask

    task automatic t_buffer();
        logic [31:0] v;
        wr(12'h80C, 32'hA1B2C3D4); rd(12'h80C, v);
        chk(v == 32'hA1B2C3D4, "R3 word", v, 32'hA1B2C3D4);
        wr(12'h87C, 32'h0BADF00D); rd(12'h87C, v);
        chk(v == 32'h0BADF00D, "R3 last word", v, 32'h0BADF00D);
    endtask

    task automatic t_xfer();
        logic [31:0] v;
        int n;
        int r0;
        wr(12'h538, (32'd2 << 25) | 32'd10);
        wr(12'h800, 32'h56341203);
        wr(12'h804, 32'h77777777);
        s_tx[4] = 8'hA5; s_tx[5] = 8'h3C; s_tx[6] = 8'h81;
        r0 = rises;
        wr(12'h500, 32'h8); wr(12'h504, 32'd4); wr(12'h508, 32'd3);
        wr(12'h500, 32'hC);
        reg_addr = 12'h500;
        #1 chk(reg_rdata[1:0] == 2'b01 && spi_cs_n, "R4 busy first", {30'b0, reg_rdata[1:0]}, 1);
        @(negedge clk);
        #1 chk(reg_rdata[1:0] == 2'b11 && !spi_cs_n, "R4 cs+ready", {spi_cs_n, reg_rdata[1:0]}, 3);
        rd(12'h550, v); chk(v != 0, "R12 state busy", v, 1);
        reg_addr = 12'h500;
        while (!spi_cs_n) @(negedge clk);
        #1 n = 0;
        while (reg_rdata[0]) begin @(negedge clk); #1 n++; end
        chk(n == 11, "R8 gap", 32'(n), 11);
        chk(rises - r0 == 56, "R5 sclk edges", 32'(rises - r0), 56);
        chk({s_rx[0], s_rx[1], s_rx[2], s_rx[3]} == 32'h03123456, "R6 out bytes",
            {s_rx[0], s_rx[1], s_rx[2], s_rx[3]}, 32'h03123456);
        chk({s_rx[4], s_rx[5], s_rx[6]} == 24'h0, "R6 mosi low", {8'h0, s_rx[4], s_rx[5], s_rx[6]}, 0);
        rd(12'h804, v); chk(v == 32'h77813CA5, "R7 rx bytes", v, 32'h77813CA5);
        rd(12'h500, v); chk(v[1:0] == 2'b10, "R9 ready held", v, 32'hA);
        wr(12'h500, 32'h0);
        rd(12'h500, v); chk(v == 0, "R9 close", v, 0);
    endtask

    task automatic t_busy_writes();
        logic [31:0] v;
        int r0;
        int n;
        wr(12'h538, 32'd6);
        wr(12'h814, 32'h11111111);
        start_txn(2, 2);
        wr(12'h504, 32'h55);
        wr(12'h814, 32'hDEADBEEF);
        reg_addr = 12'h500;
        while (spi_cs_n) @(negedge clk);
        while (!spi_cs_n) @(negedge clk);
        r0 = rises;
        reg_addr = 12'h500; reg_wdata = 32'hC; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
        #1 n = 1;
        while (reg_rdata[0]) begin @(negedge clk); #1 n++; end
        chk(n == 7, "R8 gap with trigger", 32'(n), 7);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (!spi_cs_n) begin chk(0, "R10 trigger in gap", 0, 1); break; end
        end
        chk(rises == r0, "R10 no extra sclk", 32'(rises), 32'(r0));
        rd(12'h504, v); chk(v == 2, "R10 outc frozen", v, 2);
        rd(12'h814, v); chk(v == 32'h11111111, "R10 buf frozen", v, 32'h11111111);
        wr(12'h500, 32'h0);
    endtask

    task automatic t_abort();
        logic [31:0] v;
        start_txn(8, 0);
        repeat (20) @(negedge clk);
        wr(12'h500, 32'h0);
        chk(spi_cs_n && !spi_sclk, "R9 abort pins", {30'b0, spi_cs_n, spi_sclk}, 2);
        rd(12'h500, v); chk(v == 0, "R9 abort flags", v, 0);
        rd(12'h550, v); chk(v == 0, "R9 abort state", v, 0);
    endtask

    task automatic t_srst();
        logic [31:0] v;
        start_txn(6, 2);
        repeat (15) @(negedge clk);
        wr(12'h538, (32'd1 << 28) | 32'd9);
        chk(spi_cs_n, "R11 cs high", {31'b0, spi_cs_n}, 1);
        rd(12'h550, v); chk(v == 0, "R11 state", v, 0);
        rd(12'h500, v); chk(v[1:0] == 2'b00, "R11 flags", v, 32'h8);
        rd(12'h538, v); chk(v == 32'd9, "R11 misc", v, 9);
        wr(12'h500, 32'h0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        for (int i = 0; i < 16; i++) begin s_tx[i] = 8'h00; s_rx[i] = 8'h00; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_buffer();
        t_xfer();
        t_busy_writes();
        t_abort();
        t_srst();
        done_flag = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule